// File: doc/BRIEF.md
# Codeword Byte Packer with Context Exchange

The block takes variable-length codewords, each given as a value and a bit count, and joins them into one unbroken bit sequence. The most significant bit goes first. The sequence leaves the block only as whole bytes on a valid/ready output. A flush input pads the last partial byte with zero bits so that the tail of a stream can be emitted.

Two encoders can share the packer in turn. Each encoder owns its own stream. Once every complete byte of the current stream has drained, the packer holds at most seven leftover bits. At that point an external controller can read out those bits and their count, and can load another stream's leftover bits in their place, both within a single cycle. The switch falls between codewords, because a codeword is always taken whole. As a result, each stream continues exactly where it stopped, with no bit lost and none repeated.

Top module: `cw_byte_packer`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0, `ctx_idle` is 1, `ctx_out_cnt` is 0 and `cw_ready` is 1.
- R2: An accepted codeword adds the low `cw_len` bits of `cw_bits` to the stream, starting with bit `cw_len`-1. Bits of `cw_bits` above `cw_len`-1 are ignored. `cw_len` must be 1 to MAX_LEN.
- R3: `out_valid` is high exactly when at least 8 bits are pending. `out_byte[7]` carries the earliest pending bit. While `out_valid` is high and `out_ready` is low, `out_byte` stays unchanged.
- R4: `cw_ready` is low whenever more than ACC_W-MAX_LEN bits (8 by default) are pending, and whenever `ctx_save` or `ctx_load` is high.
- R5: A cycle with `flush` high pads the pending bits with zeros up to the next multiple of 8. A codeword accepted in the same cycle is placed before the padding. With no partial byte pending, flush does nothing. Flush is ignored while `ctx_save` or `ctx_load` is high.
- R6: `ctx_idle` is high exactly when fewer than 8 bits are pending. While it is high, `ctx_out_cnt` gives the number of leftover bits. `ctx_out_bits` holds them left-aligned: the earliest bit is in bit 6 and the unused low bits are 0.
- R7: `ctx_save` alone, in a cycle with `ctx_idle` high, empties the packer on the next cycle. The values on `ctx_out_bits`/`ctx_out_cnt` during that cycle are the saved context.
- R8: `ctx_load` in a cycle with `ctx_idle` high replaces the leftover bits with the top `ctx_in_cnt` bits of `ctx_in_bits` (bit 6 first). The low bits of `ctx_in_bits` are ignored. With `ctx_save` high as well, the old context is exported in that same cycle, so the two streams swap.
- R9: `ctx_save` or `ctx_load` while `ctx_idle` is low has no effect on the pending bits.
- R10: When two codeword streams are interleaved through save/load swaps, each stream's output bytes equal the bytes obtained by packing that stream's codewords alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_valid | input | 1 | Codeword offered |
| cw_ready | output | 1 | Packer can take the offered codeword |
| cw_bits | input | MAX_LEN | Codeword value, right-aligned |
| cw_len | input | $clog2(MAX_LEN+1) | Codeword length in bits |
| flush | input | 1 | Pad the partial byte with zeros |
| out_valid | output | 1 | A complete byte is available |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Next byte of the stream |
| ctx_idle | output | 1 | No full byte pending; context exchange allowed |
| ctx_save | input | 1 | Export and clear the leftover bits |
| ctx_load | input | 1 | Load leftover bits from the context inputs |
| ctx_in_bits | input | 7 | Leftover bits to load, left-aligned |
| ctx_in_cnt | input | 3 | Number of leftover bits to load |
| ctx_out_bits | output | 7 | Current leftover bits, left-aligned |
| ctx_out_cnt | output | 3 | Current leftover bit count |

## Verification
The assertions take for granted that every offered codeword has a length from 1 to MAX_LEN, and that a context request is raised only once `ctx_idle` has been seen high. The one exception is the check that a request made while bytes are pending is ignored. The bench keeps every table entry and directed codeword within that length range. It raises save and load only after it has waited for `ctx_idle`, except in the single test that deliberately makes requests while 32 bits are pending.

// File: rtl/cwpk_pkg.sv
// Shared definitions for the codeword byte packer.
// Assumes 8-bit output bytes, so a partial byte holds at most 7 bits.
package cwpk_pkg;
    localparam int RES_W  = 7;   // widest partial byte
    localparam int RCNT_W = 3;   // bits to count a partial byte

    // Context operation chosen for the current cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SAVE = 2'd1,
        OP_LOAD = 2'd2,
        OP_SWAP = 2'd3
    } ctx_op_e;
endpackage

// File: rtl/cwpk_mask.sv
// Keeps the low `len` bits of a right-aligned value and clears the rest.
// Assumes len never exceeds W; LW must be wide enough to hold W.
module cwpk_mask #(
    parameter int W  = 32,
    parameter int LW = 6
) (
    input  logic [W-1:0]  raw,
    input  logic [LW-1:0] len,
    output logic [W-1:0]  kept
);
    // one gate per bit: a bit survives when its index is below len
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign kept[i] = raw[i] & (len > LW'(i));
    end
endmodule

// File: rtl/cwpk_merge.sv
// Next-state logic of the packer accumulator.
// Pending bits are kept left-aligned in acc_q, and every bit below them is
// zero. A byte pop shifts first, then a codeword is appended right after
// the remaining bits, then flush rounds the count up to a byte boundary.
// A context operation replaces all of that.
// Assumes the caller only asserts take when cnt (after pop) + len <= ACC_W.
module cwpk_merge
    import cwpk_pkg::*;
#(
    parameter int ACC_W   = 40,
    parameter int MAX_LEN = 32,
    parameter int CW      = 6,
    parameter int LW      = 6
) (
    input  logic [ACC_W-1:0]   acc_q,
    input  logic [CW-1:0]      cnt_q,
    input  logic               pop,
    input  logic               take,
    input  logic               flush_go,
    input  logic [MAX_LEN-1:0] cw_kept,
    input  logic [LW-1:0]      cw_len,
    input  ctx_op_e            op,
    input  logic [RES_W-1:0]   ld_bits,
    input  logic [RCNT_W-1:0]  ld_cnt,
    output logic [ACC_W-1:0]   acc_d,
    output logic [CW-1:0]      cnt_d
);
    localparam int PAD_W = ACC_W - MAX_LEN;

    logic [ACC_W-1:0] acc_p;
    logic [ACC_W-1:0] cw_ext;
    logic [CW-1:0]    cnt_p;
    logic [CW-1:0]    cnt_a;
    logic [RES_W-1:0] ld_keep;
    int               sh;

    assign cw_ext  = {{PAD_W{1'b0}}, cw_kept};
    // keep only the top ld_cnt bits of the loaded partial byte
    assign ld_keep = ld_bits & ~({RES_W{1'b1}} >> ld_cnt);

    // combine pop, append, padding and context load into the next state
    always_comb begin
        acc_p = pop ? (acc_q << 8) : acc_q;
        cnt_p = pop ? (cnt_q - CW'(8)) : cnt_q;
        sh    = ACC_W - int'(cnt_p) - int'(cw_len);
        acc_d = acc_p;
        cnt_a = cnt_p;
        if (take) begin
            acc_d = acc_p | (cw_ext << sh);
            cnt_a = cnt_p + CW'(cw_len);
        end
        cnt_d = flush_go ? ((cnt_a + CW'(7)) & ~CW'(7)) : cnt_a;
        if (op == OP_SAVE) begin
            acc_d = '0;
            cnt_d = '0;
        end else if (op == OP_LOAD || op == OP_SWAP) begin
            acc_d = {ld_keep, {(ACC_W-RES_W){1'b0}}};
            cnt_d = CW'(ld_cnt);
        end
    end
endmodule

// File: rtl/cwpk_state.sv
// Holds the accumulator bits and the pending bit count.
// Assumes a synchronous active-low reset that empties the packer.
module cwpk_state #(
    parameter int ACC_W = 40,
    parameter int CW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_d,
    input  logic [CW-1:0]    cnt_d,
    output logic [ACC_W-1:0] acc_q,
    output logic [CW-1:0]    cnt_q
);
    // register the next state, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cw_byte_packer.sv
// Packs variable-length codewords MSB-first into bytes and lets an outside
// controller swap the partial byte between streams.
// Assumes cw_len is 1..MAX_LEN and ACC_W >= MAX_LEN + 8, so that a codeword
// fits whenever at most one byte is pending.
module cw_byte_packer
    import cwpk_pkg::*;
#(
    parameter int  MAX_LEN = 32,
    parameter int  ACC_W   = 40,
    localparam int LW      = $clog2(MAX_LEN + 1),
    localparam int CW      = $clog2(ACC_W + 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cw_valid,
    output logic               cw_ready,
    input  logic [MAX_LEN-1:0] cw_bits,
    input  logic [LW-1:0]      cw_len,
    input  logic               flush,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_byte,
    output logic               ctx_idle,
    input  logic               ctx_save,
    input  logic               ctx_load,
    input  logic [RES_W-1:0]   ctx_in_bits,
    input  logic [RCNT_W-1:0]  ctx_in_cnt,
    output logic [RES_W-1:0]   ctx_out_bits,
    output logic [RCNT_W-1:0]  ctx_out_cnt
);
    localparam int ROOM = ACC_W - MAX_LEN;

    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   acc_d;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      cnt_d;
    logic [MAX_LEN-1:0] cw_kept;
    logic               ctx_req;
    logic               take;
    logic               pop;
    logic               flush_go;
    ctx_op_e            op;

    assign ctx_idle     = cnt_q < CW'(8);
    assign ctx_req      = ctx_save | ctx_load;
    assign out_valid    = !ctx_idle;
    assign out_byte     = acc_q[ACC_W-1 -: 8];
    assign cw_ready     = (cnt_q <= CW'(ROOM)) && !ctx_req;
    assign take         = cw_valid & cw_ready;
    assign pop          = out_valid & out_ready;
    assign flush_go     = flush & !ctx_req;
    assign ctx_out_bits = acc_q[ACC_W-1 -: RES_W];
    assign ctx_out_cnt  = cnt_q[RCNT_W-1:0];

    // decode the context request, honoured only when no full byte is pending
    always_comb begin
        op = OP_NONE;
        if (ctx_idle) begin
            if (ctx_save && ctx_load) op = OP_SWAP;
            else if (ctx_save)        op = OP_SAVE;
            else if (ctx_load)        op = OP_LOAD;
        end
    end

    cwpk_mask #(.W(MAX_LEN), .LW(LW)) u_mask (
        .raw  (cw_bits),
        .len  (cw_len),
        .kept (cw_kept)
    );

    cwpk_merge #(.ACC_W(ACC_W), .MAX_LEN(MAX_LEN), .CW(CW), .LW(LW)) u_merge (
        .acc_q    (acc_q),
        .cnt_q    (cnt_q),
        .pop      (pop),
        .take     (take),
        .flush_go (flush_go),
        .cw_kept  (cw_kept),
        .cw_len   (cw_len),
        .op       (op),
        .ld_bits  (ctx_in_bits),
        .ld_cnt   (ctx_in_cnt),
        .acc_d    (acc_d),
        .cnt_d    (cnt_d)
    );

    cwpk_state #(.ACC_W(ACC_W), .CW(CW)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .acc_d (acc_d),
        .cnt_d (cnt_d),
        .acc_q (acc_q),
        .cnt_q (cnt_q)
    );
endmodule

// File: rtl/cwpk_chk.sv
// Port-level properties of the codeword byte packer, bound to every instance.
// Assumes inputs follow the rules in the requirements (legal codeword length).
module cwpk_chk #(
    parameter int MAX_LEN = 32,
    parameter int LW      = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cw_valid,
    input logic          cw_ready,
    input logic [LW-1:0] cw_len,
    input logic          flush,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_byte,
    input logic          ctx_idle,
    input logic          ctx_save,
    input logic          ctx_load,
    input logic [2:0]    ctx_in_cnt,
    input logic [2:0]    ctx_out_cnt
);
    // R2: an offered codeword has a legal length
    p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> (cw_len != '0 && cw_len <= LW'(MAX_LEN)));

    // R3: a stalled byte is held
    p_hold_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R4: after a codeword longer than a byte, no room for another
    p_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_ready && cw_len > LW'(8)) |=> !cw_ready);

    // R5: a lone flush leaves a byte boundary
    p_flush_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !ctx_save && !ctx_load && !(cw_valid && cw_ready) && ctx_idle)
        |=> (ctx_out_cnt == 3'd0));

    // R7: save alone empties the packer
    p_save_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_save && !ctx_load && ctx_idle) |=> (ctx_out_cnt == 3'd0 && !out_valid));

    // R8: load sets the leftover count
    p_load_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load && ctx_idle) |=> (ctx_out_cnt == $past(ctx_in_cnt) && !out_valid));

    // R9: a request while bytes are pending and stalled changes nothing visible
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctx_save || ctx_load) && !ctx_idle && !out_ready)
        |=> (!ctx_idle && $stable(out_byte)));
endmodule

bind cw_byte_packer cwpk_chk #(.MAX_LEN(MAX_LEN), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cw_valid    (cw_valid),
    .cw_ready    (cw_ready),
    .cw_len      (cw_len),
    .flush       (flush),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_byte    (out_byte),
    .ctx_idle    (ctx_idle),
    .ctx_save    (ctx_save),
    .ctx_load    (ctx_load),
    .ctx_in_cnt  (ctx_in_cnt),
    .ctx_out_cnt (ctx_out_cnt)
);

// File: tb/cw_byte_packer_bench.sv
// Bench for cw_byte_packer: a table of interleaved codewords from two
// streams, checked against a bit-level model, then directed corner tests.
module cw_byte_packer_bench;
    localparam real CLK_NS  = 5.0;
    localparam int  MAX_LEN = 32;
    localparam int  LW      = 6;
    localparam int  NV      = 22;

    // entry = {stream, length[5:0], value[31:0]}
    localparam logic [38:0] TBL [NV] = '{
        {1'b0, 6'd5,  32'h0000_0013}, {1'b0, 6'd12, 32'h0000_0ABC},
        {1'b0, 6'd1,  32'h0000_0001}, {1'b1, 6'd7,  32'h0000_0055},
        {1'b1, 6'd32, 32'hDEAD_BEEF}, {1'b0, 6'd3,  32'h0000_0005},
        {1'b0, 6'd16, 32'h0000_1234}, {1'b1, 6'd9,  32'h0000_01A5},
        {1'b1, 6'd2,  32'h0000_0002}, {1'b1, 6'd1,  32'h0000_0000},
        {1'b0, 6'd32, 32'h8000_0001}, {1'b0, 6'd4,  32'hFFFF_FFF3},
        {1'b1, 6'd13, 32'h0000_1FFF}, {1'b0, 6'd6,  32'h0000_002A},
        {1'b1, 6'd20, 32'h000A_BCDE}, {1'b1, 6'd5,  32'hFFFF_FFEA},
        {1'b1, 6'd3,  32'h0000_0006}, {1'b0, 6'd8,  32'h0000_00C3},
        {1'b0, 6'd11, 32'h0000_0401}, {1'b1, 6'd31, 32'h1234_5678},
        {1'b0, 6'd2,  32'h0000_0001}, {1'b1, 6'd7,  32'h0000_0011}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cw_valid = 1'b0;
    logic               cw_ready;
    logic [MAX_LEN-1:0] cw_bits = '0;
    logic [LW-1:0]      cw_len = '0;
    logic               flush = 1'b0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [7:0]         out_byte;
    logic               ctx_idle;
    logic               ctx_save = 1'b0;
    logic               ctx_load = 1'b0;
    logic [6:0]         ctx_in_bits = '0;
    logic [2:0]         ctx_in_cnt = '0;
    logic [6:0]         ctx_out_bits;
    logic [2:0]         ctx_out_cnt;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   cur = 1'b0;
    bit   bp_en = 1'b0;
    bit   rdy_force = 1'b1;
    int   bp_cnt = 0;
    bit   exp_a[$];
    bit   exp_b[$];
    logic [7:0] got_a[$];
    logic [7:0] got_b[$];
    logic [6:0] sv_bits [2];
    logic [2:0] sv_cnt [2];

    cw_byte_packer #(.MAX_LEN(MAX_LEN), .ACC_W(40)) u_cw_byte_packer (
        .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
        .cw_bits(cw_bits), .cw_len(cw_len), .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .ctx_idle(ctx_idle), .ctx_save(ctx_save), .ctx_load(ctx_load),
        .ctx_in_bits(ctx_in_bits), .ctx_in_cnt(ctx_in_cnt),
        .ctx_out_bits(ctx_out_bits), .ctx_out_cnt(ctx_out_cnt)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    // output consumer pattern, changed just after each rising edge
    always begin
        @(posedge clk);
        #1;
        bp_cnt++;
        out_ready = bp_en ? (bp_cnt % 4 != 1) : rdy_force;
    end

    // byte collector, sampling mid-cycle
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (cur) got_b.push_back(out_byte);
            else     got_a.push_back(out_byte);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic add_exp(input bit s, input logic [31:0] v, input int len);
        for (int b = len - 1; b >= 0; b--) begin
            if (s) exp_b.push_back(v[b]);
            else   exp_a.push_back(v[b]);
        end
    endtask

    task automatic pad_exp(input bit s);
        if (s) while (exp_b.size() % 8 != 0) exp_b.push_back(1'b0);
        else   while (exp_a.size() % 8 != 0) exp_a.push_back(1'b0);
    endtask

    // offer one codeword and hold it until accepted; optionally flush with it
    task automatic send_cw(input logic [31:0] v, input int len, input bit fl);
        cw_valid = 1'b1;
        cw_bits  = v;
        cw_len   = LW'(len);
        flush    = fl;
        forever begin
            @(negedge clk);
            if (cw_ready) begin
                tick();
                break;
            end
            tick();
        end
        cw_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    task automatic wait_idle();
        while (!ctx_idle) tick();
        repeat (2) tick();
    endtask

    // hand the packer over to stream s, keeping the leaving stream's context
    task automatic swap_to(input bit s);
        while (!ctx_idle) tick();
        ctx_save    = 1'b1;
        ctx_load    = 1'b1;
        ctx_in_bits = sv_bits[s];
        ctx_in_cnt  = sv_cnt[s];
        @(negedge clk);
        sv_bits[cur] = ctx_out_bits;
        sv_cnt[cur]  = ctx_out_cnt;
        tick();
        ctx_save = 1'b0;
        ctx_load = 1'b0;
        cur      = s;
    endtask

    task automatic cmp_stream(input bit s);
        int nb;
        logic [7:0] e;
        logic [7:0] g;
        nb = s ? exp_b.size() / 8 : exp_a.size() / 8;
        chk((s ? got_b.size() : got_a.size()) == nb, "R10 byte count",
            s ? got_b.size() : got_a.size(), nb);
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < 8; k++) e[7-k] = s ? exp_b[8*i+k] : exp_a[8*i+k];
            if (s) g = (i < got_b.size()) ? got_b[i] : 8'hxx;
            else   g = (i < got_a.size()) ? got_a[i] : 8'hxx;
            chk(g === e, "R10/R2 stream byte", g, e);
        end
    endtask

    task automatic expect_last(input logic [7:0] e, input string req);
        chk(got_a.size() > 0 && got_a[got_a.size()-1] === e, req,
            (got_a.size() > 0) ? got_a[got_a.size()-1] : 8'hxx, e);
    endtask

    initial begin
        sv_bits[0] = '0; sv_bits[1] = '0;
        sv_cnt[0]  = '0; sv_cnt[1]  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(ctx_idle == 1'b1, "R1 ctx_idle", ctx_idle, 1);
        chk(ctx_out_cnt == 3'd0, "R1 ctx_out_cnt", ctx_out_cnt, 0);
        chk(cw_ready == 1'b1, "R1 cw_ready", cw_ready, 1);
        tick();
        rst_n = 1'b1;
        tick();

        // table walk: interleaved streams, swaps with partial bytes (R8, R10)
        bp_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            bit s;
            s = TBL[i][38];
            if (s != cur) swap_to(s);
            send_cw(TBL[i][31:0], int'(TBL[i][37:32]), 1'b0);
            add_exp(s, TBL[i][31:0], int'(TBL[i][37:32]));
        end
        do_flush();
        pad_exp(cur);
        swap_to(!cur);
        do_flush();
        pad_exp(cur);
        wait_idle();
        bp_en = 1'b0;
        rdy_force = 1'b1;
        tick();
        cmp_stream(1'b0);
        cmp_stream(1'b1);

        // R3/R4/R9: stall with 32 bits pending, requests while busy
        cur = 1'b0;
        got_a.delete();
        rdy_force = 1'b0;
        repeat (2) tick();
        send_cw(32'hA5C3_0F11, 32, 1'b0);
        @(negedge clk);
        chk(cw_ready == 1'b0, "R4 ready low when full", cw_ready, 0);
        chk(out_valid && out_byte == 8'hA5, "R3 first byte", out_byte, 8'hA5);
        tick();
        ctx_save = 1'b1;
        ctx_load = 1'b1;
        ctx_in_bits = 7'h7F;
        ctx_in_cnt  = 3'd5;
        tick();
        ctx_save = 1'b0;
        ctx_load = 1'b0;
        repeat (2) tick();
        @(negedge clk);
        chk(out_byte == 8'hA5, "R3 byte held while stalled", out_byte, 8'hA5);
        chk(ctx_idle == 1'b0, "R9 request ignored when busy", ctx_idle, 0);
        tick();
        rdy_force = 1'b1;
        wait_idle();
        chk(got_a.size() == 4, "R9 byte count kept", got_a.size(), 4);
        if (got_a.size() == 4) begin
            chk({got_a[0], got_a[1], got_a[2], got_a[3]} == 32'hA5C3_0F11,
                "R9 bytes unchanged", {got_a[0], got_a[1], got_a[2], got_a[3]},
                32'hA5C3_0F11);
        end
        chk(ctx_out_cnt == 3'd0, "R9 no load happened", ctx_out_cnt, 0);

        // R6: residual export format
        send_cw(32'h0000_0005, 3, 1'b0);
        @(negedge clk);
        chk(ctx_idle == 1'b1, "R6 idle with 3 bits", ctx_idle, 1);
        chk(ctx_out_bits == 7'h50, "R6 left-aligned bits", ctx_out_bits, 7'h50);
        chk(ctx_out_cnt == 3'd3, "R6 count", ctx_out_cnt, 3);
        tick();

        // R5: flush pads with zeros, then flush on empty does nothing
        got_a.delete();
        do_flush();
        wait_idle();
        expect_last(8'hA0, "R5 padded byte");
        do_flush();
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 flush on empty", out_valid, 0);
        chk(got_a.size() == 1, "R5 no extra byte", got_a.size(), 1);
        tick();

        // R7/R4: save alone empties
        send_cw(32'h0000_001B, 5, 1'b0);
        ctx_save = 1'b1;
        @(negedge clk);
        chk(ctx_out_bits == 7'h6C && ctx_out_cnt == 3'd5, "R7 saved context",
            {ctx_out_cnt, ctx_out_bits}, {3'd5, 7'h6C});
        chk(cw_ready == 1'b0, "R4 ready low during request", cw_ready, 0);
        tick();
        ctx_save = 1'b0;
        @(negedge clk);
        chk(ctx_out_cnt == 3'd0 && out_valid == 1'b0, "R7 emptied",
            {out_valid, ctx_out_cnt}, 0);
        tick();
        do_flush();
        repeat (2) tick();
        chk(got_a.size() == 1, "R7 nothing left to flush", got_a.size(), 1);

        // R8: load keeps only the top ctx_in_cnt bits
        ctx_load    = 1'b1;
        ctx_in_bits = 7'h3F;
        ctx_in_cnt  = 3'd2;
        tick();
        ctx_load = 1'b0;
        @(negedge clk);
        chk(ctx_out_bits == 7'h20 && ctx_out_cnt == 3'd2, "R8 loaded context",
            {ctx_out_cnt, ctx_out_bits}, {3'd2, 7'h20});
        tick();
        send_cw(32'h0000_0033, 6, 1'b0);
        wait_idle();
        expect_last(8'h73, "R8 continued stream");

        // R5/R2: codeword and flush together, codeword placed first
        send_cw(32'hFFFF_FFF7, 3, 1'b1);
        wait_idle();
        expect_last(8'hE0, "R5 codeword before padding");
        chk(got_a.size() == 3, "R2 byte total", got_a.size(), 3);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule